// File: doc/BRIEF.md
# Speculative Bus Cycle Terminator

This block ends processor bus cycles without waiting for the slow checks behind them. A cycle opens when the address strobe is seen high while the block is idle. The mode input, sampled at that same edge, picks one of two terminations. The synchronous one ends the cycle with a single terminate strobe and can finish in two clocks. The asynchronous one uses an acknowledge strobe and needs at least three clocks. In both modes the strobe goes up in the first clock after the cycle opens. At that point the block does not yet know whether the access hit the cache or whether the data parity is good.

The cache-hit result and the parity result each arrive with their own ready flag. In the first clock where the mode's minimum length is met and both flags are high, the block gives its verdict alongside the strobe. It pulses a data-take qualifier when both results are good. It pulses retry when either one is bad, and in that case no data is handed back and the requester must run the cycle again. A result that is still missing at that point adds a wait state, and the strobe stays up. After a verdict the strobe drops. A new cycle can only start once the address strobe has been seen low.

Top module: `spec_bus_term`

## Requirements
- R1: While reset is held and in the first clock after it, sync_end_o, async_ack_o, retry_o and data_take_o are all low.
- R2: A cycle opens at a rising clock edge where addr_strobe_i is high and the block is idle. mode_async_i is sampled at that edge (0 = synchronous, 1 = asynchronous). In the next clock sync_end_o (synchronous) or async_ack_o (asynchronous) is raised, whatever the ready flags are doing.
- R3: In synchronous mode the verdict can be given in the first clock that sync_end_o is high, which makes a two-clock cycle.
- R4: In asynchronous mode no verdict is given in the first clock that async_ack_o is high, even if both results are ready. The earliest verdict is in the second such clock, which makes a three-clock cycle.
- R5: In the verdict clock, if hit_i = 1 and parity_good_i = 1, data_take_o is high for that clock and retry_o is low.
- R6: In the verdict clock, if hit_i = 0 or parity_good_i = 0, retry_o is high together with the strobe and data_take_o stays low.
- R7: If hit_ready_i or parity_ready_i is low in a clock where a verdict would be allowed, the block adds a wait state. The strobe stays high and data_take_o and retry_o stay low. Each such clock lengthens the cycle by one clock.
- R8: In the clock after a verdict, both strobes are low. They stay low while addr_strobe_i remains high, and no new cycle opens until addr_strobe_i has been sampled low.
- R9: Changing mode_async_i after a cycle has opened has no effect on which strobe that cycle uses.
- R10: If addr_strobe_i drops while a strobe is high, no verdict is given in that clock and both strobes are low in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strobe_i | input | 1 | High while the processor holds a valid address |
| mode_async_i | input | 1 | 0 = synchronous termination, 1 = asynchronous termination |
| hit_i | input | 1 | Cache lookup result, 1 = hit |
| hit_ready_i | input | 1 | hit_i is valid |
| parity_good_i | input | 1 | Parity check result, 1 = good |
| parity_ready_i | input | 1 | parity_good_i is valid |
| sync_end_o | output | 1 | Synchronous terminate strobe |
| async_ack_o | output | 1 | Asynchronous acknowledge strobe |
| retry_o | output | 1 | Cycle must be rerun, no data returned |
| data_take_o | output | 1 | Data valid; the cycle completes this clock |

## Verification
The bench runs a hit, a miss, a parity failure and late results on each check, in both modes. In every strobe clock it compares all four outputs, so a design that judged one clock too early or too late would be caught by a misplaced data_take_o or retry_o. One asynchronous cycle has both results ready in its first acknowledge clock. A design that ignored the three-clock minimum would accept data there. The bench keeps the address strobe high after each verdict and flips the mode input in the middle of cycles. A design that restarted without seeing the strobe low, or that followed the live mode input, would show a strobe where none belongs. The bench also drops the address strobe in the middle of a cycle while the results are ready and good. A design that did not gate its verdict on the strobe would report completion for a cycle the processor has already abandoned.

// File: rtl/spec_bus_term_pkg.sv
package spec_bus_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/spec_bus_verdict.sv
// Folds any number of ready/result check pairs into one readiness flag and one pass flag.
module spec_bus_verdict #(
    parameter int NCHK = 2
) (
    input  logic [NCHK-1:0] rdy_i,
    input  logic [NCHK-1:0] ok_i,
    output logic            ready_o,
    output logic            pass_o
);
    logic [NCHK:0] rdy_chain;
    logic [NCHK:0] ok_chain;

    assign rdy_chain[0] = 1'b1;
    assign ok_chain[0]  = 1'b1;

    for (genvar g = 0; g < NCHK; g++) begin : g_fold
        assign rdy_chain[g+1] = rdy_chain[g] & rdy_i[g];
        assign ok_chain[g+1]  = ok_chain[g] & ok_i[g];
    end

    assign ready_o = rdy_chain[NCHK];
    assign pass_o  = ok_chain[NCHK];
endmodule

// File: rtl/spec_bus_seq.sv
// Cycle sequencer: opens a cycle, raises the mode strobe at once, enforces the
// per-mode minimum length and issues the data-take or retry verdict.
module spec_bus_seq
    import spec_bus_term_pkg::*;
#(
    parameter int SYNC_MIN  = 2,
    parameter int ASYNC_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic mode_async_i,
    input  logic ready_i,
    input  logic pass_i,
    output logic sync_end_o,
    output logic async_ack_o,
    output logic retry_o,
    output logic data_take_o
);
    localparam int CMAX = (ASYNC_MIN > SYNC_MIN) ? ASYNC_MIN : SYNC_MIN;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SMIN  = CW'(SYNC_MIN);
    localparam logic [CW-1:0] AMIN  = CW'(ASYNC_MIN);
    localparam logic [CW-1:0] CTOP  = CW'(CMAX);
    localparam logic [CW-1:0] FIRST = CW'(2);

    typedef struct packed {
        cyc_state_e     st;
        logic           async_m;
        logic [CW-1:0]  clk_no;
    } seq_t;

    seq_t s_q, s_d;
    logic allowed, active, decide;

    always_comb begin
        active  = (s_q.st == ST_ACTIVE);
        allowed = s_q.clk_no >= (s_q.async_m ? AMIN : SMIN);
        decide  = active && strobe_i && allowed && ready_i;

        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (strobe_i) begin
                    s_d.st      = ST_ACTIVE;
                    s_d.async_m = mode_async_i;
                    s_d.clk_no  = FIRST;
                end
            end
            ST_ACTIVE: begin
                if (!strobe_i) begin
                    s_d.st = ST_IDLE;
                end else if (decide) begin
                    s_d.st = ST_DRAIN;
                end else if (s_q.clk_no < CTOP) begin
                    s_d.clk_no = s_q.clk_no + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!strobe_i) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= ST_IDLE;
            s_q.async_m <= 1'b0;
            s_q.clk_no  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_end_o  = active && !s_q.async_m;
    assign async_ack_o = active && s_q.async_m;
    assign data_take_o = decide && pass_i;
    assign retry_o     = decide && !pass_i;

    // R8
    verdict_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_take_o || retry_o) |=> (!sync_end_o && !async_ack_o));

    // R4
    async_first_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(async_ack_o) |-> (!data_take_o && !retry_o));

    // R7
    wait_holds_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_end_o || async_ack_o) && strobe_i && !ready_i) |=> (sync_end_o || async_ack_o));

    // R9
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_end_o |=> !async_ack_o);

    // R6
    retry_only_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> (!pass_i && (sync_end_o || async_ack_o)));

    // R10
    abort_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_end_o || async_ack_o) && !strobe_i) |=> (!sync_end_o && !async_ack_o));

    // R5
    single_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_take_o, retry_o}));
endmodule

// File: rtl/spec_bus_term.sv
module spec_bus_term #(
    parameter int SYNC_MIN  = 2,
    parameter int ASYNC_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_strobe_i,
    input  logic mode_async_i,
    input  logic hit_i,
    input  logic hit_ready_i,
    input  logic parity_good_i,
    input  logic parity_ready_i,
    output logic sync_end_o,
    output logic async_ack_o,
    output logic retry_o,
    output logic data_take_o
);
    localparam int NCHK = 2;

    logic ready, pass;

    spec_bus_verdict #(.NCHK(NCHK)) u_verdict (
        .rdy_i   ({parity_ready_i, hit_ready_i}),
        .ok_i    ({parity_good_i, hit_i}),
        .ready_o (ready),
        .pass_o  (pass)
    );

    spec_bus_seq #(.SYNC_MIN(SYNC_MIN), .ASYNC_MIN(ASYNC_MIN)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (addr_strobe_i),
        .mode_async_i (mode_async_i),
        .ready_i      (ready),
        .pass_i       (pass),
        .sync_end_o   (sync_end_o),
        .async_ack_o  (async_ack_o),
        .retry_o      (retry_o),
        .data_take_o  (data_take_o)
    );
endmodule

// File: tb/sim_spec_bus_term.sv
module sim_spec_bus_term;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic as_r = 1'b0, mode_r = 1'b0, hit_r = 1'b0, hrdy_r = 1'b0, par_r = 1'b0, prdy_r = 1'b0;
    logic sync_end, async_ack, retry, take;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    spec_bus_term u0 (
        .clk(clk), .rst_n(rst_n), .addr_strobe_i(as_r), .mode_async_i(mode_r),
        .hit_i(hit_r), .hit_ready_i(hrdy_r), .parity_good_i(par_r), .parity_ready_i(prdy_r),
        .sync_end_o(sync_end), .async_ack_o(async_ack), .retry_o(retry), .data_take_o(take)
    );

    // vector: {mode, hit, parity, hit_wait[1:0], parity_wait[1:0]}
    localparam int NV = 12;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_1_1_00_00, 7'b0_0_1_00_00, 7'b0_1_0_00_00, 7'b0_1_1_01_00,
        7'b0_1_0_00_10, 7'b0_0_0_01_01,
        7'b1_1_1_00_00, 7'b1_0_1_00_00, 7'b1_1_0_00_00, 7'b1_1_1_10_00,
        7'b1_0_1_00_01, 7'b1_1_1_01_11
    };

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        chk(sync_end, 1'b0, req, "sync_end low");
        chk(async_ack, 1'b0, req, "async_ack low");
        chk(retry, 1'b0, req, "retry low");
        chk(take, 1'b0, req, "data_take low");
    endtask

    task automatic run_vec(input logic m, input logic h, input logic p,
                           input int hw, input int pw);
        int mn, d;
        logic good;
        mn = m ? 2 : 1;
        d = mn + ((hw > pw) ? hw : pw);
        good = h & p;
        @(negedge clk);
        as_r = 1'b1; mode_r = m; hit_r = h; par_r = p; hrdy_r = 1'b0; prdy_r = 1'b0;
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            hrdy_r = (k >= mn + hw);
            prdy_r = (k >= mn + pw);
            mode_r = ~m;                     // R9: live mode changes ignored
            #1;
            chk(sync_end, !m, "R2", "sync strobe");
            chk(async_ack, m, "R2", "async strobe");
            chk(take, (k == d) && good, (k == d) ? "R5" : "R7", "data_take");
            chk(retry, (k == d) && !good, (k == d) ? "R6" : "R7", "retry");
        end
        @(negedge clk);
        hrdy_r = 1'b0; prdy_r = 1'b0;
        #1 quiet("R8");
        @(negedge clk);
        #1 quiet("R8");                      // strobe still high: no restart
        as_r = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset
        @(negedge clk); #1 quiet("R1");
        @(negedge clk); rst_n = 1'b1;
        #1 quiet("R1");

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:2]), int'(VEC[i][1:0]));

        // R3: synchronous two-clock cycle with results ready at once
        run_vec(1'b0, 1'b1, 1'b1, 0, 0);

        // R4: asynchronous, results ready and good in the first acknowledge clock
        @(negedge clk);
        as_r = 1'b1; mode_r = 1'b1; hit_r = 1'b1; par_r = 1'b1; hrdy_r = 1'b1; prdy_r = 1'b1;
        @(negedge clk); #1;
        chk(async_ack, 1'b1, "R4", "ack first clock");
        chk(take, 1'b0, "R4", "no take first clock");
        chk(retry, 1'b0, "R4", "no retry first clock");
        @(negedge clk); #1;
        chk(take, 1'b1, "R4", "take second clock");
        as_r = 1'b0; hrdy_r = 1'b0; prdy_r = 1'b0;
        @(negedge clk); #1 quiet("R8");

        // R10: abandon an asynchronous cycle with good results ready
        @(negedge clk);
        as_r = 1'b1; mode_r = 1'b1;
        @(negedge clk); #1 chk(async_ack, 1'b1, "R10", "ack before abort");
        @(negedge clk);
        as_r = 1'b0; hrdy_r = 1'b1; prdy_r = 1'b1;
        #1;
        chk(take, 1'b0, "R10", "no take on abort");
        chk(retry, 1'b0, "R10", "no retry on abort");
        @(negedge clk); #1 quiet("R10");

        // R10: abandon a synchronous cycle in its first clock
        hrdy_r = 1'b0; prdy_r = 1'b0;
        @(negedge clk);
        as_r = 1'b1; mode_r = 1'b0;
        @(negedge clk);
        as_r = 1'b0; hrdy_r = 1'b1; prdy_r = 1'b1;
        #1;
        chk(sync_end, 1'b1, "R10", "sync strobe before abort");
        chk(take, 1'b0, "R10", "no sync take on abort");
        @(negedge clk); #1 quiet("R10");
        hrdy_r = 1'b0; prdy_r = 1'b0;

        // R2: strobe appears before any result is ready
        @(negedge clk);
        as_r = 1'b1; mode_r = 1'b0;
        @(negedge clk); #1;
        chk(sync_end, 1'b1, "R2", "speculative strobe");
        chk(take, 1'b0, "R7", "no take while not ready");
        as_r = 1'b0;
        @(negedge clk); #1 quiet("R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule